// File: doc/BRIEF.md
# Serial Debug Source and Probe Register

This block lets a host, through a serial boundary-scan-style link, read a vector of internal design signals and drive a vector of control signals into the design. One shift register carries both directions. A capture strobe loads the probe vector into it in parallel. Shift strobes move the contents out on serial out while new data enters on serial in. An update strobe copies the low bits into a hold register that feeds the source output. The host thereby reads a snapshot of the probes in the same pass that it writes new source data.

The shift register is as long as the wider of the two ports; either width may be zero, and the length then follows the other one. The source output starts at a parameterised initial value. In the optional synchronous mode, the source value is re-registered into a user clock domain. A toggle crossing carries each update to that domain, and a clock enable input gates the final register. In the plain mode the hold register drives the output directly and the enable input has no effect.

Top module: `dbg_src_probe_reg`

## Requirements
- R1: While reset is asserted and after it is released, before any update, the source output equals the low SRC_W bits of SRC_INIT.
- R2: A capture strobe loads the probe input into shift bits [PROBE_W-1:0] in one shift-clock edge, and clears any shift bits above PROBE_W.
- R3: Each shift strobe moves the register one place toward serial out, so the value leaves least significant bit first. The serial-in bit enters at the top position, so after LEN shifts the register holds the host word, with its most significant bit sent last.
- R4: An update strobe copies shift bits [SRC_W-1:0] into the hold stage in one edge, so all source bits change together.
- R5: When strobes coincide, capture takes precedence over shift and shift over update, and only the winning operation takes effect on that edge.
- R6: Captures and shifts without an update leave the source output unchanged.
- R7: In synchronous mode (SYNC_SRC=1), the new value reaches the source output only on a source-clock edge with src_ce high. An update that arrives while src_ce is low is kept pending and applied on the first edge with src_ce high.
- R8: A port whose width parameter is zero is kept one bit wide. A zero-width probe input is ignored and captures load zeros; a zero-width source output is driven to 0. The shift length then equals the other width.
- R9: In plain mode (SYNC_SRC=0), the source output follows the hold stage on the edge after the update strobe, whatever src_ce is.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| tck | input | 1 | Shift clock for the serial side |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously in each domain |
| tdi | input | 1 | Serial data in, enters the top of the shift register |
| tdo | output | 1 | Serial data out, bit 0 of the shift register |
| cap_en | input | 1 | Capture strobe: parallel load of the probe input |
| shift_en | input | 1 | Shift strobe: move one bit toward tdo |
| upd_en | input | 1 | Update strobe: copy the low source bits to the hold stage |
| probe_in | input | max(PROBE_W,1) | Internal signals to be sampled |
| src_clk | input | 1 | User clock for the synchronous source mode |
| src_ce | input | 1 | Clock enable for the source re-register (synchronous mode only) |
| src_out | output | max(SRC_W,1) | Control vector driven into the design |

## Verification
A table of probe and source pairs drives full capture–shift–update rounds. The pairs include alternating bits, all ones, all zeros, a single set top bit and a single set low bit. The alternating and single-bit patterns show whether the bit order or the shift length is off by one position, and the all-ones and all-zeros pairs expose stuck bits on the path. Directed cases apply coincident strobes to separate the priority order. They hold the enable low across an update to show that the transfer waits and is kept pending. A second instance, in plain mode with a zero probe width and a five-bit source, shows that the shift length follows the source width, that captures read back zeros and that the enable is ignored.

// File: rtl/dsp_pkg.sv
package dsp_pkg;

  typedef enum logic [1:0] {
    OP_IDLE    = 2'd0,
    OP_CAPTURE = 2'd1,
    OP_SHIFT   = 2'd2,
    OP_UPDATE  = 2'd3
  } chain_op_e;

  function automatic int unsigned wmax(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

  // a zero-width port is kept as a single bit
  function automatic int unsigned wport(input int unsigned w);
    return (w == 0) ? 1 : w;
  endfunction

endpackage

// File: rtl/dsp_rst_sync.sv
module dsp_rst_sync (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n_o
);
  logic s1_q, s2_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      s1_q <= 1'b0;
      s2_q <= 1'b0;
    end else begin
      s1_q <= 1'b1;
      s2_q <= s1_q;
    end
  end

  assign rst_n_o = s2_q;
endmodule

// File: rtl/dsp_chain.sv
module dsp_chain import dsp_pkg::*; #(
  parameter int unsigned LEN      = 12,
  parameter int unsigned PROBE_W  = 12,
  parameter int unsigned PWE      = 12,
  parameter int unsigned SWE      = 8,
  parameter logic [255:0] SRC_INIT = '0
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           tdi,
  input  logic           cap_en,
  input  logic           shift_en,
  input  logic           upd_en,
  input  logic [PWE-1:0] probe_in,
  output logic           tdo,
  output logic           upd_fire,
  output logic [LEN-1:0] chain_q,
  output logic [SWE-1:0] hold_q
);
  chain_op_e      op;
  logic [LEN-1:0] cap_vec;
  logic [LEN-1:0] shf_vec;
  logic [LEN-1:0] chain_d;
  logic [SWE-1:0] hold_d;
  logic           chain_ce;
  logic           hold_ce;

  // capture value: probe bits at the bottom, zeros above
  generate
    if (PROBE_W == 0) begin : g_cap_none
      assign cap_vec = '0;
    end else if (PROBE_W < LEN) begin : g_cap_pad
      assign cap_vec = {{(LEN-PROBE_W){1'b0}}, probe_in};
    end else begin : g_cap_full
      assign cap_vec = probe_in;
    end
  endgenerate

  // shift value: one place toward bit 0, serial in at the top
  generate
    if (LEN == 1) begin : g_shf_one
      assign shf_vec = tdi;
    end else begin : g_shf_many
      assign shf_vec = {tdi, chain_q[LEN-1:1]};
    end
  endgenerate

  // priority: capture, then shift, then update
  always_comb begin
    if (cap_en)        op = OP_CAPTURE;
    else if (shift_en) op = OP_SHIFT;
    else if (upd_en)   op = OP_UPDATE;
    else               op = OP_IDLE;
  end

  always_comb begin
    chain_ce = 1'b0;
    hold_ce  = 1'b0;
    chain_d  = chain_q;
    hold_d   = hold_q;
    case (op)
      OP_CAPTURE: begin
        chain_ce = 1'b1;
        chain_d  = cap_vec;
      end
      OP_SHIFT: begin
        chain_ce = 1'b1;
        chain_d  = shf_vec;
      end
      OP_UPDATE: begin
        hold_ce = 1'b1;
        hold_d  = chain_q[SWE-1:0];
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q <= '0;
    end else if (chain_ce) begin
      chain_q <= chain_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_q <= SRC_INIT[SWE-1:0];
    end else if (hold_ce) begin
      hold_q <= hold_d;
    end
  end

  assign tdo      = chain_q[0];
  assign upd_fire = hold_ce;
endmodule

// File: rtl/dsp_src_xfer.sv
module dsp_src_xfer #(
  parameter int unsigned  SWE      = 8,
  parameter bit           SYNC_SRC = 1'b1,
  parameter logic [255:0] SRC_INIT = '0
) (
  input  logic           tck,
  input  logic           tck_rst_n,
  input  logic           upd_fire,
  input  logic [SWE-1:0] hold_q,
  input  logic           src_clk,
  input  logic           arst_n,
  input  logic           src_ce,
  output logic [SWE-1:0] src_out
);
  generate
    if (SYNC_SRC) begin : g_sync
      logic           src_rst_n;
      logic           tgl_q, tgl_d;
      logic           s1_q, s2_q, s3_q;
      logic           pend_q, pend_d;
      logic [SWE-1:0] src_q, src_d;
      logic           seen;
      logic           xfer;

      dsp_rst_sync u_src_rst (
        .clk     (src_clk),
        .arst_n  (arst_n),
        .rst_n_o (src_rst_n)
      );

      // update toggle in the shift-clock domain
      assign tgl_d = tgl_q ^ upd_fire;

      always_ff @(posedge tck or negedge tck_rst_n) begin
        if (!tck_rst_n) tgl_q <= 1'b0;
        else            tgl_q <= tgl_d;
      end

      // two-flop synchroniser plus an edge-detect stage
      always_ff @(posedge src_clk or negedge src_rst_n) begin
        if (!src_rst_n) begin
          s1_q <= 1'b0;
          s2_q <= 1'b0;
          s3_q <= 1'b0;
        end else begin
          s1_q <= tgl_q;
          s2_q <= s1_q;
          s3_q <= s2_q;
        end
      end

      assign seen   = (s2_q ^ s3_q) | pend_q;
      assign xfer   = seen & src_ce;
      assign pend_d = seen & ~src_ce;
      assign src_d  = xfer ? hold_q : src_q;

      always_ff @(posedge src_clk or negedge src_rst_n) begin
        if (!src_rst_n) begin
          pend_q <= 1'b0;
          src_q  <= SRC_INIT[SWE-1:0];
        end else begin
          pend_q <= pend_d;
          src_q  <= src_d;
        end
      end

      assign src_out = src_q;
    end else begin : g_plain
      assign src_out = hold_q;
    end
  endgenerate
endmodule

// File: rtl/dbg_src_probe_reg.sv
module dbg_src_probe_reg import dsp_pkg::*; #(
  parameter int unsigned  PROBE_W  = 12,
  parameter int unsigned  SRC_W    = 8,
  parameter bit           SYNC_SRC = 1'b1,
  parameter logic [255:0] SRC_INIT = 256'hA5,
  localparam int unsigned PWE      = wport(PROBE_W),
  localparam int unsigned SWE      = wport(SRC_W)
) (
  input  logic           tck,
  input  logic           rst_n,
  input  logic           tdi,
  output logic           tdo,
  input  logic           cap_en,
  input  logic           shift_en,
  input  logic           upd_en,
  input  logic [PWE-1:0] probe_in,
  input  logic           src_clk,
  input  logic           src_ce,
  output logic [SWE-1:0] src_out
);
  localparam int unsigned LEN = wport(wmax(PROBE_W, SRC_W));

  logic           tck_rst_n;
  logic           upd_fire;
  logic [LEN-1:0] chain_q;
  logic [SWE-1:0] hold_q;

  dsp_rst_sync u_tck_rst (
    .clk     (tck),
    .arst_n  (rst_n),
    .rst_n_o (tck_rst_n)
  );

  dsp_chain #(
    .LEN      (LEN),
    .PROBE_W  (PROBE_W),
    .PWE      (PWE),
    .SWE      (SWE),
    .SRC_INIT (SRC_INIT)
  ) u_chain (
    .clk      (tck),
    .rst_n    (tck_rst_n),
    .tdi      (tdi),
    .cap_en   (cap_en),
    .shift_en (shift_en),
    .upd_en   (upd_en),
    .probe_in (probe_in),
    .tdo      (tdo),
    .upd_fire (upd_fire),
    .chain_q  (chain_q),
    .hold_q   (hold_q)
  );

  generate
    if (SRC_W == 0) begin : g_no_src
      assign src_out = '0;
    end else begin : g_src
      dsp_src_xfer #(
        .SWE      (SWE),
        .SYNC_SRC (SYNC_SRC),
        .SRC_INIT (SRC_INIT)
      ) u_xfer (
        .tck       (tck),
        .tck_rst_n (tck_rst_n),
        .upd_fire  (upd_fire),
        .hold_q    (hold_q),
        .src_clk   (src_clk),
        .arst_n    (rst_n),
        .src_ce    (src_ce),
        .src_out   (src_out)
      );
    end
  endgenerate
endmodule

// File: rtl/dsp_src_probe_chk.sv
module dsp_src_probe_chk #(
  parameter int unsigned LEN      = 12,
  parameter int unsigned PWE      = 12,
  parameter int unsigned PROBE_W  = 12,
  parameter int unsigned SWE      = 8,
  parameter bit          SYNC_SRC = 1'b1
) (
  input logic           tck,
  input logic           rst_n,
  input logic           tck_rst_n,
  input logic           tdi,
  input logic           cap_en,
  input logic           shift_en,
  input logic           upd_en,
  input logic [PWE-1:0] probe_in,
  input logic [LEN-1:0] chain_q,
  input logic [SWE-1:0] hold_q,
  input logic           src_clk,
  input logic           src_ce,
  input logic [SWE-1:0] src_out
);
  // R2
  capture_load_chk: assert property (@(posedge tck) disable iff (!tck_rst_n)
    cap_en |=> (chain_q[0] == ((PROBE_W == 0) ? 1'b0 : $past(probe_in[0]))));

  // R3
  shift_entry_chk: assert property (@(posedge tck) disable iff (!tck_rst_n)
    (shift_en && !cap_en) |=> (chain_q[LEN-1] == $past(tdi)));

  // R5
  shift_blocks_update_chk: assert property (@(posedge tck) disable iff (!tck_rst_n)
    (cap_en || shift_en || !upd_en) |=> $stable(hold_q));

  // R4
  update_copy_chk: assert property (@(posedge tck) disable iff (!tck_rst_n)
    (upd_en && !cap_en && !shift_en) |=> (hold_q == $past(chain_q[SWE-1:0])));

  generate
    if (SYNC_SRC) begin : g_sync_chk
      // R7
      src_ce_gate_chk: assert property (@(posedge src_clk) disable iff (!rst_n)
        !src_ce |=> $stable(src_out));
    end
  endgenerate
endmodule

bind dbg_src_probe_reg dsp_src_probe_chk #(
  .LEN      (LEN),
  .PWE      (PWE),
  .PROBE_W  (PROBE_W),
  .SWE      (SWE),
  .SYNC_SRC (SYNC_SRC)
) u_chk (
  .tck       (tck),
  .rst_n     (rst_n),
  .tck_rst_n (tck_rst_n),
  .tdi       (tdi),
  .cap_en    (cap_en),
  .shift_en  (shift_en),
  .upd_en    (upd_en),
  .probe_in  (probe_in),
  .chain_q   (chain_q),
  .hold_q    (hold_q),
  .src_clk   (src_clk),
  .src_ce    (src_ce),
  .src_out   (src_out)
);

// File: tb/dbg_src_probe_reg_tb.sv
module dbg_src_probe_reg_tb;
  localparam int PW  = 12;
  localparam int SW  = 8;
  localparam int LEN = 12;
  localparam int NV  = 6;

  // {probe, source}
  localparam logic [PW+SW-1:0] VEC [NV] = '{
    {12'hAAA, 8'h55},
    {12'hFFF, 8'hFF},
    {12'h000, 8'h00},
    {12'h800, 8'h80},
    {12'h001, 8'h01},
    {12'h3C5, 8'h9A}
  };

  logic tck = 1'b0;
  logic rst_n;
  logic tdi, cap_en, shift_en, upd_en, src_ce;
  logic [PW-1:0] probe_in;
  logic tdo;
  logic [SW-1:0] src_out;

  logic a_tdi, a_cap, a_shift, a_upd, a_tdo;
  logic [0:0] a_probe;
  logic [4:0] a_src;

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;

  always #2.5 tck = ~tck;

  dbg_src_probe_reg #(.PROBE_W(PW), .SRC_W(SW), .SYNC_SRC(1'b1), .SRC_INIT(256'hA5)) u_dut (
    .tck(tck), .rst_n(rst_n), .tdi(tdi), .tdo(tdo), .cap_en(cap_en),
    .shift_en(shift_en), .upd_en(upd_en), .probe_in(probe_in),
    .src_clk(tck), .src_ce(src_ce), .src_out(src_out)
  );

  dbg_src_probe_reg #(.PROBE_W(0), .SRC_W(5), .SYNC_SRC(1'b0), .SRC_INIT(256'h0C)) u_dut_plain (
    .tck(tck), .rst_n(rst_n), .tdi(a_tdi), .tdo(a_tdo), .cap_en(a_cap),
    .shift_en(a_shift), .upd_en(a_upd), .probe_in(a_probe),
    .src_clk(tck), .src_ce(src_ce), .src_out(a_src)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic cycles(input int n);
    for (int i = 0; i < n; i++) @(negedge tck);
  endtask

  task automatic capture(input logic [PW-1:0] p);
    probe_in = p;
    cap_en   = 1'b1;
    @(negedge tck);
    cap_en   = 1'b0;
  endtask

  // shifts LEN bits in, returns the bits seen on tdo in order
  task automatic shift_word(input logic [LEN-1:0] din, output logic [LEN-1:0] dout);
    for (int i = 0; i < LEN; i++) begin
      tdi      = din[i];
      shift_en = 1'b1;
      dout[i]  = tdo;
      @(negedge tck);
    end
    shift_en = 1'b0;
  endtask

  task automatic update();
    upd_en = 1'b1;
    @(negedge tck);
    upd_en = 1'b0;
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge tck);
    if (!done) begin
      bad++;
      total++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin : main
    logic [LEN-1:0] rd;
    logic [4:0]     ard;
    rst_n = 1'b0;
    tdi = 0; cap_en = 0; shift_en = 0; upd_en = 0; src_ce = 1'b1;
    probe_in = '0;
    a_tdi = 0; a_cap = 0; a_shift = 0; a_upd = 0; a_probe = 1'b1;
    cycles(3);
    check("R1 init in reset", src_out, 8'hA5);
    check("R1 init plain in reset", a_src, 5'h0C);
    rst_n = 1'b1;
    cycles(4);
    check("R1 init after reset", src_out, 8'hA5);

    // table walk: capture, read out while writing, update
    for (int v = 0; v < NV; v++) begin
      capture(VEC[v][PW+SW-1:SW]);
      shift_word({{(LEN-SW){1'b0}}, VEC[v][SW-1:0]}, rd);
      check("R2 R3 probe readback", rd, VEC[v][PW+SW-1:SW]);
      update();
      cycles(6);
      check("R4 R7 source applied", src_out, VEC[v][SW-1:0]);
    end

    // R6: capture and shift without update leave source alone
    capture(12'h123);
    shift_word(12'h0C3, rd);
    cycles(6);
    check("R6 no update keeps source", src_out, 8'h9A);

    // R5: capture wins over shift
    probe_in = 12'h5A6; cap_en = 1'b1; shift_en = 1'b1; tdi = 1'b1;
    @(negedge tck);
    cap_en = 1'b0; shift_en = 1'b0;
    shift_word(12'h000, rd);
    check("R5 capture over shift", rd, 12'h5A6);

    // R5: shift wins over update (chain holds zeros, source stays)
    tdi = 1'b1; shift_en = 1'b1; upd_en = 1'b1;
    @(negedge tck);
    shift_en = 1'b0; upd_en = 1'b0;
    cycles(6);
    check("R5 shift over update", src_out, 8'h9A);

    // R7: enable low holds the transfer pending
    shift_word(12'h03C, rd);
    src_ce = 1'b0;
    update();
    cycles(8);
    check("R7 enable low blocks", src_out, 8'h9A);
    src_ce = 1'b1;
    cycles(2);
    check("R7 pending applied", src_out, 8'h3C);

    // plain instance: zero probe width, 5-bit source
    src_ce = 1'b0;
    for (int i = 0; i < 5; i++) begin
      a_tdi = ((5'b10110 >> i) & 5'b1) != 0;
      a_shift = 1'b1;
      @(negedge tck);
    end
    a_shift = 1'b0;
    a_upd = 1'b1;
    @(negedge tck);
    a_upd = 1'b0;
    check("R8 R9 plain update with enable low", a_src, 5'b10110);
    a_cap = 1'b1;
    @(negedge tck);
    a_cap = 1'b0;
    for (int i = 0; i < 5; i++) begin
      ard[i] = a_tdo;
      a_tdi = 1'b1;
      a_shift = 1'b1;
      @(negedge tck);
    end
    a_shift = 1'b0;
    check("R8 zero probe captures zeros", ard, 5'b00000);
    a_upd = 1'b1;
    @(negedge tck);
    a_upd = 1'b0;
    check("R8 shift length five", a_src, 5'b11111);
    check("R6 plain source unaffected by other instance", src_out, 8'h3C);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule